// File: doc/BRIEF.md
# DMA Channel Register File

This block is the processor-facing register bank of a four-channel DMA controller. Software reaches it over an 8-bit I/O bus made of a 4-bit offset, a write strobe, a read strobe and a byte of write data. Every channel holds a 16-bit start address and a 16-bit start count, each with a live "current" copy that the transfer engine advances. It also holds a mode byte and a mask bit. Because the bus is one byte wide, 16-bit values go through single byte ports. One shared pointer bit decides whether an access reaches the low or the high byte, and it flips on every such access.

Besides the per-channel ports, the bank decodes a set of command offsets: status read, single-channel mask, mode load, pointer reset, master clear, mask clear and write-all-masks. The per-channel current address, current count, mode fields and mask go out to a transfer engine. The engine reports progress back through an update strobe. On terminal count, a channel set for autoinit reloads its current copies from the start values.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, the byte pointer selects the low byte, all address, count and mode registers are zero, and the status byte reads 0x00.
- R2: A write at offset 2n loads channel n's address and a write at offset 2n+1 loads its count, n = 0..3. The byte written is the low byte when the pointer is clear and the high byte when it is set. Both the start copy and the current copy take that byte.
- R3: The pointer flips on every read or write at offsets 0x0 to 0x7. An access at any other offset leaves it unchanged.
- R4: Any write at offset 0xC returns the pointer to the low-byte state.
- R5: A read at offset 2n or 2n+1 returns the pointer-selected byte of channel n's current address or current count.
- R6: A write at offset 0xA picks a channel with bits 1:0. Bit 2 = 1 sets that channel's mask and bit 2 = 0 clears it. The other masks are unchanged.
- R7: A write at offset 0xF copies data bits 3:0 into the masks, with bit n going to channel n. A write at offset 0xE clears all four masks.
- R8: A write at offset 0xB picks a channel with bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode output. Within the stored mode, bits 7:6 are the transfer type (01 single, 11 cascade), bit 5 is decrement, bit 4 is autoinit and bits 3:2 are the direction (01 I/O to memory, 10 memory to I/O).
- R9: A write at offset 0xD is a master clear. It sets all masks, returns the pointer to low, zeroes all modes and clears the status flags. Address and count contents are kept.
- R10: A read at offset 0x8 returns the terminal-count flags in bits 3:0 (bit n = channel n) and zeros in bits 7:4, then clears the flags. A flag raised in the same cycle as that read survives it.
- R11: An engine update (eng_upd with channel eng_ch) loads that channel's current address and count from eng_addr and eng_cnt. If eng_tc is also high, the channel's status flag is set. If that channel's autoinit bit is set, the current copies reload from the start values instead of taking the engine values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| eng_upd | input | 1 | Transfer engine update strobe |
| eng_ch | input | 2 | Channel being updated |
| eng_tc | input | 1 | Terminal count reached on this update |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| ch_mask_o | output | 4 | Mask bit per channel |
| ch_addr_o | output | 64 | Current address, channel n in bits 16n+15:16n |
| ch_cnt_o | output | 64 | Current count, channel n in bits 16n+15:16n |
| ch_mode_o | output | 24 | Mode, channel n in bits 6n+5:6n |

## Verification
On every cycle, the embedded assertions check the following. The pointer flips after each register-port access and returns low after a pointer reset or master clear. A written byte lands in the current copy. Master clear forces masks set and modes to zero. A mask-clear command empties the masks. A status read empties the flags unless a new terminal count arrives at the same time, and a terminal count always leaves its flag set. Only the bench scenarios can show the values that move through the byte ports. These are the assembly of 16-bit values from two writes, read-back of engine-advanced current values, and the reload of start values on autoinit. They also cover the mask and mode field encodings, the exact status byte, and that accesses at non-register offsets leave the pointer alone.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int BUS_W = 8;
  localparam int REG_W = 16;
  localparam int OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_STATUS   = 4'h8;
  localparam logic [OFS_W-1:0] OFS_MASK_ONE = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE     = 4'hB;
  localparam logic [OFS_W-1:0] OFS_PTR_RST  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MCLR     = 4'hD;
  localparam logic [OFS_W-1:0] OFS_MASK_CLR = 4'hE;
  localparam logic [OFS_W-1:0] OFS_MASK_ALL = 4'hF;

  // stored mode = write data bits 7:2
  typedef struct packed {
    logic [1:0] xfer;
    logic       dec;
    logic       autoinit;
    logic [1:0] dir;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                input logic [BUS_W-1:0] b,
                                                input logic hi);
    put_byte = hi ? {b, v[BUS_W-1:0]} : {v[REG_W-1:BUS_W], b};
  endfunction

  function automatic logic [BUS_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                 input logic hi);
    pick_byte = hi ? v[REG_W-1:BUS_W] : v[BUS_W-1:0];
  endfunction

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [OFS_W-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic             reg_acc,
  output logic [CH_W-1:0]  reg_ch,
  output logic             reg_is_cnt,
  output logic [NCH-1:0]   wr_addr_ch,
  output logic [NCH-1:0]   wr_cnt_ch,
  output logic             stat_rd,
  output logic             mask_one_wr,
  output logic             mode_wr,
  output logic             ptr_rst_wr,
  output logic             mclr_wr,
  output logic             mask_clr_wr,
  output logic             mask_all_wr
);

  localparam logic [OFS_W-1:0] REG_END = OFS_W'(2 * NCH);

  logic in_reg_space;

  assign in_reg_space = (io_addr < REG_END);
  assign reg_acc      = in_reg_space && (io_wr || io_rd);
  assign reg_ch       = io_addr[CH_W:1];
  assign reg_is_cnt   = io_addr[0];

  for (genvar c = 0; c < NCH; c++) begin : g_wsel
    assign wr_addr_ch[c] = io_wr && in_reg_space && (reg_ch == CH_W'(c)) && !reg_is_cnt;
    assign wr_cnt_ch[c]  = io_wr && in_reg_space && (reg_ch == CH_W'(c)) && reg_is_cnt;
  end

  assign stat_rd     = io_rd && (io_addr == OFS_STATUS);
  assign mask_one_wr = io_wr && (io_addr == OFS_MASK_ONE);
  assign mode_wr     = io_wr && (io_addr == OFS_MODE);
  assign ptr_rst_wr  = io_wr && (io_addr == OFS_PTR_RST);
  assign mclr_wr     = io_wr && (io_addr == OFS_MCLR);
  assign mask_clr_wr = io_wr && (io_addr == OFS_MASK_CLR);
  assign mask_all_wr = io_wr && (io_addr == OFS_MASK_ALL);

endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic clear,
  output logic ptr_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_hi <= 1'b0;
    else if (clear) ptr_hi <= 1'b0;
    else if (flip)  ptr_hi <= ~ptr_hi;
  end

  assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clear) |=> (ptr_hi != $past(ptr_hi)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && !clear) |=> $stable(ptr_hi));

  assert_ptr_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ptr_hi);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_addr,
  input  logic             wr_cnt,
  input  logic [BUS_W-1:0] wdata,
  input  logic             ptr_hi,
  input  logic             mode_wr,
  input  mode_t            mode_in,
  input  logic             mclr,
  input  logic             upd,
  input  logic             upd_tc,
  input  logic [REG_W-1:0] upd_addr,
  input  logic [REG_W-1:0] upd_cnt,
  output logic [REG_W-1:0] cur_addr,
  output logic [REG_W-1:0] cur_cnt,
  output mode_t            mode
);

  logic [REG_W-1:0] base_addr;
  logic [REG_W-1:0] base_cnt;
  logic             reload;

  assign reload = upd && upd_tc && mode.autoinit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (reload) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else if (upd) begin
        cur_addr <= upd_addr;
        cur_cnt  <= upd_cnt;
      end
      // processor byte write wins over engine for its register
      if (wr_addr) begin
        base_addr <= put_byte(base_addr, wdata, ptr_hi);
        cur_addr  <= put_byte(cur_addr, wdata, ptr_hi);
      end
      if (wr_cnt) begin
        base_cnt <= put_byte(base_cnt, wdata, ptr_hi);
        cur_cnt  <= put_byte(cur_cnt, wdata, ptr_hi);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= '0;
    else if (mclr)    mode <= '0;
    else if (mode_wr) mode <= mode_in;
  end

  assert_addr_lo_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && !ptr_hi) |=> (cur_addr[BUS_W-1:0] == $past(wdata)));

  assert_cnt_hi_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && ptr_hi) |=> (cur_cnt[REG_W-1:BUS_W] == $past(wdata)));

  assert_mode_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mode == '0));

endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tc_set,
  input  logic           rd_clr,
  input  logic           mclr,
  output logic [NCH-1:0] flags
);

  logic [NCH-1:0] kept;

  assign kept = (rd_clr || mclr) ? '0 : flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | tc_set;
  end

  assert_read_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (tc_set == '0)) |=> (flags == '0));

  assert_tc_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((flags & $past(tc_set)) == $past(tc_set)));

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OFS_W-1:0]        io_addr,
  input  logic [BUS_W-1:0]        io_wdata,
  input  logic                    io_wr,
  input  logic                    io_rd,
  output logic [BUS_W-1:0]        io_rdata,
  input  logic                    eng_upd,
  input  logic [CH_W-1:0]         eng_ch,
  input  logic                    eng_tc,
  input  logic [REG_W-1:0]        eng_addr,
  input  logic [REG_W-1:0]        eng_cnt,
  output logic [NCH-1:0]          ch_mask_o,
  output logic [NCH*REG_W-1:0]    ch_addr_o,
  output logic [NCH*REG_W-1:0]    ch_cnt_o,
  output logic [NCH*MODE_W-1:0]   ch_mode_o
);

  logic            reg_acc;
  logic [CH_W-1:0] reg_ch;
  logic            reg_is_cnt;
  logic [NCH-1:0]  wr_addr_ch;
  logic [NCH-1:0]  wr_cnt_ch;
  logic            stat_rd;
  logic            mask_one_wr;
  logic            mode_wr;
  logic            ptr_rst_wr;
  logic            mclr_wr;
  logic            mask_clr_wr;
  logic            mask_all_wr;
  logic            ptr_hi;
  logic [NCH-1:0]  tc_set;
  logic [NCH-1:0]  tc_flags;
  logic [CH_W-1:0] cmd_ch;
  mode_t           mode_in;

  logic [REG_W-1:0] cur_addr [NCH];
  logic [REG_W-1:0] cur_cnt  [NCH];

  assign cmd_ch  = io_wdata[CH_W-1:0];
  assign mode_in = mode_t'(io_wdata[BUS_W-1:2]);

  dma_cmd_decode #(.NCH(NCH)) u_dec (
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .reg_acc    (reg_acc),
    .reg_ch     (reg_ch),
    .reg_is_cnt (reg_is_cnt),
    .wr_addr_ch (wr_addr_ch),
    .wr_cnt_ch  (wr_cnt_ch),
    .stat_rd    (stat_rd),
    .mask_one_wr(mask_one_wr),
    .mode_wr    (mode_wr),
    .ptr_rst_wr (ptr_rst_wr),
    .mclr_wr    (mclr_wr),
    .mask_clr_wr(mask_clr_wr),
    .mask_all_wr(mask_all_wr)
  );

  dma_byte_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .flip  (reg_acc),
    .clear (ptr_rst_wr || mclr_wr),
    .ptr_hi(ptr_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic  upd_here;
    mode_t mode_c;

    assign upd_here  = eng_upd && (eng_ch == CH_W'(c));
    assign tc_set[c] = upd_here && eng_tc;

    dma_chan_regs u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (wr_addr_ch[c]),
      .wr_cnt  (wr_cnt_ch[c]),
      .wdata   (io_wdata),
      .ptr_hi  (ptr_hi),
      .mode_wr (mode_wr && (cmd_ch == CH_W'(c))),
      .mode_in (mode_in),
      .mclr    (mclr_wr),
      .upd     (upd_here),
      .upd_tc  (eng_tc),
      .upd_addr(eng_addr),
      .upd_cnt (eng_cnt),
      .cur_addr(cur_addr[c]),
      .cur_cnt (cur_cnt[c]),
      .mode    (mode_c)
    );

    assign ch_addr_o[c*REG_W +: REG_W]   = cur_addr[c];
    assign ch_cnt_o[c*REG_W +: REG_W]    = cur_cnt[c];
    assign ch_mode_o[c*MODE_W +: MODE_W] = mode_c;
  end

  dma_status #(.NCH(NCH)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .tc_set(tc_set),
    .rd_clr(stat_rd),
    .mclr  (mclr_wr),
    .flags (tc_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ch_mask_o <= '1;
    else if (mclr_wr)     ch_mask_o <= '1;
    else if (mask_clr_wr) ch_mask_o <= '0;
    else if (mask_all_wr) ch_mask_o <= io_wdata[NCH-1:0];
    else if (mask_one_wr) ch_mask_o[cmd_ch] <= io_wdata[2];
  end

  always_comb begin
    io_rdata = '0;
    if (reg_acc && io_rd)
      io_rdata = pick_byte(reg_is_cnt ? cur_cnt[reg_ch] : cur_addr[reg_ch], ptr_hi);
    else if (stat_rd)
      io_rdata = BUS_W'(tc_flags);
  end

  assert_mclr_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_wr |=> (ch_mask_o == '1));

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr_wr |=> (ch_mask_o == '0));

  assert_mask_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_one_wr |=> (ch_mask_o[$past(cmd_ch)] == $past(io_wdata[2])));

endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        eng_upd = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic        eng_tc = 1'b0;
  logic [15:0] eng_addr = '0;
  logic [15:0] eng_cnt = '0;
  logic [3:0]  ch_mask_o;
  logic [63:0] ch_addr_o;
  logic [63:0] ch_cnt_o;
  logic [23:0] ch_mode_o;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;

  rd_item_t exp_q[$];

  always #10 clk = ~clk;

  dma_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .eng_upd(eng_upd),
    .eng_ch(eng_ch), .eng_tc(eng_tc), .eng_addr(eng_addr), .eng_cnt(eng_cnt),
    .ch_mask_o(ch_mask_o), .ch_addr_o(ch_addr_o), .ch_cnt_o(ch_cnt_o),
    .ch_mode_o(ch_mode_o)
  );

  // monitor: compares read data a quarter period before the capturing edge
  always @(negedge clk) begin
    #5;
    if (io_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", io_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        if (io_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s read: actual %02h expected %02h", it.tag, io_rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    io_addr = ofs; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ofs, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    io_addr = ofs; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic upd(input logic [1:0] c, input logic tc, input logic [15:0] a,
                     input logic [15:0] n);
    @(negedge clk);
    eng_upd = 1'b1; eng_ch = c; eng_tc = tc; eng_addr = a; eng_cnt = n;
    @(negedge clk);
    eng_upd = 1'b0; eng_tc = 1'b0;
  endtask

  function automatic logic [15:0] addr_of(input int c);
    return ch_addr_o[c*16 +: 16];
  endfunction
  function automatic logic [15:0] cnt_of(input int c);
    return ch_cnt_o[c*16 +: 16];
  endfunction
  function automatic logic [5:0] mode_of(input int c);
    return ch_mode_o[c*6 +: 6];
  endfunction

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(32'(ch_mask_o), 32'hF, "R1 masks");
    chk(ch_addr_o[31:0] | ch_addr_o[63:32], 0, "R1 addr");
    chk(ch_cnt_o[31:0] | ch_cnt_o[63:32], 0, "R1 cnt");
    chk(32'(ch_mode_o), 0, "R1 mode");
    rd(4'h8, 8'h00, "R1 status");

    // R2 two-byte loads
    wr(4'hC, 8'h00);
    wr(4'h2, 8'h34);
    wr(4'h2, 8'h12);
    chk(32'(addr_of(1)), 32'h1234, "R2 ch1 addr");
    wr(4'h7, 8'hFF);
    wr(4'h7, 8'h01);
    chk(32'(cnt_of(3)), 32'h01FF, "R2 ch3 cnt");

    // R5 read back
    rd(4'h7, 8'hFF, "R5 cnt lo");
    rd(4'h7, 8'h01, "R5 cnt hi");

    // R3 pointer flips on reads, not on command writes
    rd(4'h2, 8'h34, "R3 lo");
    wr(4'hA, 8'h01);
    rd(4'h2, 8'h12, "R3 hi after mask write");

    // R4 pointer reset
    rd(4'h2, 8'h34, "R4 pre");
    wr(4'hC, 8'hFF);
    rd(4'h2, 8'h34, "R4 back to lo");
    wr(4'hC, 8'h00);

    // R6 single mask
    chk(32'(ch_mask_o), 32'hD, "R6 clear ch1");
    wr(4'hA, 8'h02);
    chk(32'(ch_mask_o), 32'h9, "R6 clear ch2");
    wr(4'hA, 8'h05);
    chk(32'(ch_mask_o), 32'hB, "R6 set ch1");

    // R7 mask all / mask clear
    wr(4'hF, 8'h05);
    chk(32'(ch_mask_o), 32'h5, "R7 mask all");
    wr(4'hE, 8'h00);
    chk(32'(ch_mask_o), 32'h0, "R7 mask clear");

    // R8 mode
    wr(4'hB, 8'h56);
    chk(32'(mode_of(2)), 32'h15, "R8 ch2 mode");
    wr(4'hB, 8'hC3);
    chk(32'(mode_of(3)), 32'h30, "R8 ch3 mode");
    chk(32'(mode_of(2)), 32'h15, "R8 ch2 kept");

    // R11 engine updates, autoinit reload of start values
    wr(4'h4, 8'hCD);
    wr(4'h4, 8'hAB);
    wr(4'h5, 8'h10);
    wr(4'h5, 8'h00);
    upd(2'd2, 1'b0, 16'hABCE, 16'h000F);
    chk(32'(addr_of(2)), 32'hABCE, "R11 ch2 addr");
    chk(32'(cnt_of(2)), 32'h000F, "R11 ch2 cnt");
    upd(2'd2, 1'b1, 16'hABDD, 16'hFFFF);
    chk(32'(addr_of(2)), 32'hABCD, "R11 autoinit addr");
    chk(32'(cnt_of(2)), 32'h0010, "R11 autoinit cnt");
    upd(2'd1, 1'b1, 16'h1300, 16'hFFFF);
    chk(32'(addr_of(1)), 32'h1300, "R11 ch1 addr");
    chk(32'(cnt_of(1)), 32'hFFFF, "R11 ch1 cnt");

    // R10 status read and clear
    rd(4'h8, 8'h06, "R10 flags");
    rd(4'h8, 8'h00, "R10 cleared");
    begin : same_cycle
      rd_item_t it;
      it.exp = 8'h00; it.tag = "R10 same-cycle";
      exp_q.push_back(it);
      @(negedge clk);
      io_addr = 4'h8; io_rd = 1'b1;
      eng_upd = 1'b1; eng_ch = 2'd0; eng_tc = 1'b1; eng_addr = '0; eng_cnt = '0;
      @(negedge clk);
      io_rd = 1'b0; eng_upd = 1'b0; eng_tc = 1'b0;
    end
    rd(4'h8, 8'h01, "R10 flag survived");

    // R5 current value after engine update
    rd(4'h2, 8'h00, "R5 cur lo");
    rd(4'h2, 8'h13, "R5 cur hi");

    // R9 master clear
    wr(4'h0, 8'h55);
    upd(2'd3, 1'b1, 16'h2222, 16'h3333);
    wr(4'hD, 8'h00);
    chk(32'(ch_mask_o), 32'hF, "R9 masks");
    chk(32'(ch_mode_o), 0, "R9 modes");
    chk(32'(addr_of(1)), 32'h1300, "R9 addr kept");
    chk(32'(cnt_of(3)), 32'h3333, "R9 cnt kept");
    rd(4'h8, 8'h00, "R9 status");
    rd(4'h0, 8'h55, "R9 pointer lo");
    rd(4'h0, 8'h00, "R9 pointer hi");

    // R3 write at status offset leaves pointer
    wr(4'h8, 8'hFF);
    rd(4'h0, 8'h55, "R3 status write no flip");

    repeat (2) @(negedge clk);
    chk(32'(exp_q.size()), 0, "R5 queue drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule